// File: doc/BRIEF.md
# JTAG Reset-Into-Debug Sequencer

This block brings every device on a serial JTAG scan chain out of system reset already halted in debug mode. A single start pulse begins the sequence. The block pulls the shared system reset low, then holds the test reset low for a set time and releases it, all while system reset stays low. It then clocks the TAP controllers through a forced Test-Logic-Reset and one instruction-register scan. That scan loads the same debug-request opcode into every device on the chain. Only after a short idle period in Run-Test/Idle does it release system reset. The targets therefore leave reset in debug mode and execute no instruction first.

TCK is divided down from the system clock. The wait before test reset, the test-reset pulse and the idle time after the scan are each counted in TCK periods. No TCK edges are produced before test reset is released. The bits returned on the chain's TDO during the scan are kept for inspection. The chain length, the instruction length, the opcode, the clock ratio and the three delays are parameters. All three delays must be at least 1.

Top module: `jtag_dbg_entry`

## Requirements
- R1: After the synchronous reset `rst`, `sys_rst_n` and `trst_n` are 1, and `tck`, `busy` and `done` are 0.
- R2: The clock edge that samples `start` high in the idle state drives `sys_rst_n` to 0 and `busy` to 1. Both stay that way for exactly (PRE_TCKS + TRST_TCKS + NUM_DEV*IR_LEN + 12 + POST_TCKS) × 2 × CLK_DIV system clock cycles.
- R3: `trst_n` goes low PRE_TCKS×2×CLK_DIV cycles after `sys_rst_n` goes low and stays low for TRST_TCKS×2×CLK_DIV cycles. It is low only while `sys_rst_n` is low.
- R4: `tck` rises only while `trst_n` is 1 and `sys_rst_n` is 0. Each high phase lasts CLK_DIV system cycles. `tms` and `tdi` change only together with a falling `tck`, so both are stable at every rising edge.
- R5: After test reset is released, the TMS sequence presented to the chain's rising TCK edges is as follows. First five 1s, then 0,1,1,0,0 (Run-Test/Idle, Select-DR, Select-IR, Capture-IR, Shift-IR). Then NUM_DEV×IR_LEN shift bits, with TMS at 1 only on the last of them. Then 1 (Update-IR) and 0 (Run-Test/Idle). Every device's updated instruction then equals OPCODE, with each device's copy shifted in least significant bit first.
- R6: After Update-IR, exactly POST_TCKS rising TCK edges occur in Run-Test/Idle before `sys_rst_n` returns to 1.
- R7: `cap_tdo[k]` holds the `tdo_in` value sampled at the k-th Shift-IR rising edge. Bit 0 is the first bit. For a chain whose devices each capture value C, the result is C replicated NUM_DEV times.
- R8: `done` is a single-cycle pulse, once per sequence. It occurs in the same cycle that `sys_rst_n` returns to 1 and `busy` returns to 0.
- R9: A `start` pulse while `busy` is 1 is ignored. The running sequence keeps its length, and only one `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run the sequence |
| tdo_in | input | 1 | Scan data returned from the last device on the chain |
| sys_rst_n | output | 1 | System reset to all targets, active low |
| trst_n | output | 1 | Test reset to all targets, active low |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Scan data into the first device on the chain |
| busy | output | 1 | High from start until the sequence finishes |
| done | output | 1 | One-cycle pulse when system reset is released |
| cap_tdo | output | NUM_DEV*IR_LEN | TDO bits captured during the instruction scan, first bit in bit 0 |

## Verification
The assertions rely on two assumptions. First, the chain drives `tdo_in` from its falling TCK edge, so the value is settled well before the rising edge at which it is sampled. Second, `start` is a synchronous pulse. The chain model in the bench changes its TDO only on falling TCK, and it enters Test-Logic-Reset whenever test reset is low. The bench drives `start` only between clock edges, and it issues one extra pulse while a sequence is running to exercise the ignore rule. Two different capture values in the chain model give different TDO patterns, so the captured register is checked against non-trivial data.

// File: rtl/jde_pkg.sv
package jde_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_TRST,
    ST_SCAN,
    ST_POST
  } jde_state_e;
endpackage

// File: rtl/jde_tck_gen.sv
module jde_tck_gen #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic gate,
  output logic tck,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          ph;
  logic          tc;

  assign tc       = (cnt == CW'(CLK_DIV - 1));
  assign rise_evt = run && tc && !ph;
  assign fall_evt = run && tc && ph;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      ph  <= 1'b0;
      tck <= 1'b0;
    end else if (tc) begin
      cnt <= '0;
      ph  <= ~ph;
      tck <= gate & ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: with the gate closed, a half-period boundary leaves tck low
  p_gated_low_r4: assert property (@(posedge clk) disable iff (rst)
    (tc && run && !gate) |=> !tck);
endmodule

// File: rtl/jde_ir_shifter.sv
module jde_ir_shifter #(
  parameter int unsigned NUM_DEV = 3,
  parameter int unsigned IR_LEN  = 4,
  parameter logic [IR_LEN-1:0] OPCODE = 4'hB
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic                        shift,
  input  logic                        cap_en,
  input  logic                        tdo_in,
  output logic                        out_bit,
  output logic [NUM_DEV*IR_LEN-1:0]   cap
);
  localparam int unsigned NL = NUM_DEV * IR_LEN;

  logic [NL-1:0] pat;

  assign out_bit = pat[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pat <= '0;
      cap <= '0;
    end else begin
      if (load) begin
        pat <= {NUM_DEV{OPCODE}};
        cap <= '0;
      end else begin
        if (shift) pat <= {1'b0, pat[NL-1:1]};
        if (cap_en) cap <= {tdo_in, cap[NL-1:1]};
      end
    end
  end
endmodule

// File: rtl/jtag_dbg_entry.sv
module jtag_dbg_entry #(
  parameter int unsigned NUM_DEV   = 3,
  parameter int unsigned IR_LEN    = 4,
  parameter logic [IR_LEN-1:0] OPCODE = 4'hB,
  parameter int unsigned CLK_DIV   = 2,
  parameter int unsigned PRE_TCKS  = 2,
  parameter int unsigned TRST_TCKS = 3,
  parameter int unsigned POST_TCKS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      tdo_in,
  output logic                      sys_rst_n,
  output logic                      trst_n,
  output logic                      tck,
  output logic                      tms,
  output logic                      tdi,
  output logic                      busy,
  output logic                      done,
  output logic [NUM_DEV*IR_LEN-1:0] cap_tdo
);
  import jde_pkg::*;

  localparam int unsigned NL    = NUM_DEV * IR_LEN;
  localparam int unsigned SH0   = 10;
  localparam int unsigned STEPS = NL + 12;
  localparam int unsigned IW    = $clog2(STEPS + 1);
  localparam int unsigned MAX_A = (PRE_TCKS > TRST_TCKS) ? PRE_TCKS : TRST_TCKS;
  localparam int unsigned MAXD  = (MAX_A > POST_TCKS) ? MAX_A : POST_TCKS;
  localparam int unsigned DW    = $clog2(MAXD + 1);

  jde_state_e    state;
  logic [DW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          sh_q;
  logic          gate;
  logic          rise_evt, fall_evt;
  logic          load, shift_en, cap_en, pat_bit;

  function automatic logic in_shift(input logic [IW-1:0] k);
    return (k >= IW'(SH0)) && (k < IW'(SH0 + NL));
  endfunction

  function automatic logic tms_at(input logic [IW-1:0] k);
    if (k < IW'(5))                           return 1'b1;
    if (k == IW'(5))                          return 1'b0;
    if (k == IW'(6) || k == IW'(7))           return 1'b1;
    if (k < IW'(SH0 + NL - 1))                return 1'b0;
    if (k == IW'(SH0 + NL - 1) || k == IW'(SH0 + NL)) return 1'b1;
    return 1'b0;
  endfunction

  assign load     = (state == ST_IDLE) && start;
  assign shift_en = (state == ST_SCAN) && fall_evt && (idx != IW'(STEPS)) && in_shift(idx);
  assign cap_en   = (state == ST_SCAN) && rise_evt && sh_q;

  jde_tck_gen #(.CLK_DIV(CLK_DIV)) u_tck (
    .clk(clk), .rst(rst), .run(busy), .gate(gate),
    .tck(tck), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  jde_ir_shifter #(.NUM_DEV(NUM_DEV), .IR_LEN(IR_LEN), .OPCODE(OPCODE)) u_shf (
    .clk(clk), .rst(rst), .load(load), .shift(shift_en), .cap_en(cap_en),
    .tdo_in(tdo_in), .out_bit(pat_bit), .cap(cap_tdo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sys_rst_n <= 1'b1;
      trst_n    <= 1'b1;
      tms       <= 1'b0;
      tdi       <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      gate      <= 1'b0;
      cnt       <= '0;
      idx       <= '0;
      sh_q      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_PRE;
          sys_rst_n <= 1'b0;
          busy      <= 1'b1;
          cnt       <= '0;
        end
        ST_PRE: if (fall_evt) begin
          if (cnt == DW'(PRE_TCKS - 1)) begin
            trst_n <= 1'b0;
            state  <= ST_TRST;
            cnt    <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_TRST: if (fall_evt) begin
          if (cnt == DW'(TRST_TCKS - 1)) begin
            trst_n <= 1'b1;
            state  <= ST_SCAN;
            gate   <= 1'b1;
            tms    <= tms_at('0);
            tdi    <= 1'b0;
            sh_q   <= 1'b0;
            idx    <= IW'(1);
          end else cnt <= cnt + 1'b1;
        end
        ST_SCAN: if (fall_evt) begin
          if (idx == IW'(STEPS)) begin
            state <= ST_POST;
            tms   <= 1'b0;
            tdi   <= 1'b0;
            sh_q  <= 1'b0;
            cnt   <= DW'(1);
          end else begin
            tms  <= tms_at(idx);
            sh_q <= in_shift(idx);
            tdi  <= in_shift(idx) ? pat_bit : 1'b0;
            idx  <= idx + 1'b1;
          end
        end
        ST_POST: if (fall_evt) begin
          if (cnt == DW'(POST_TCKS)) begin
            sys_rst_n <= 1'b1;
            busy      <= 1'b0;
            done      <= 1'b1;
            gate      <= 1'b0;
            state     <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: test reset only inside held system reset
  p_trst_inside_r3: assert property (@(posedge clk) disable iff (rst)
    !trst_n |-> !sys_rst_n);
  // R4: TAP clocked only after test reset release and before system reset release
  p_tck_window_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(tck) |-> (trst_n && !sys_rst_n));
  // R4: scan inputs steady at each rising TCK
  p_tms_tdi_stable_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(tck) |-> ($stable(tms) && $stable(tdi)));
  // R2: system reset held for the whole busy window
  p_busy_holds_rst_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sys_rst_n);
  // R8: done is one cycle and coincides with release
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_release_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (sys_rst_n && !busy && $past(busy)));
  // R9: a start during a run does not end or restart it
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !fall_evt) |=> (busy && $stable(cnt)));
endmodule

// File: tb/sim_jtag_dbg_entry.sv
module sim_jtag_dbg_entry;
  localparam int N = 3;
  localparam int L = 4;
  localparam logic [L-1:0] OP = 4'hB;
  localparam int DIV = 2;
  localparam int D1 = 2;
  localparam int D2 = 3;
  localparam int D3 = 2;
  localparam int NL = N * L;
  localparam int STEPS = NL + 12;
  localparam int KT = D1 + D2 + STEPS + D3;

  localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHDR = 4, E1DR = 5, PDR = 6, E2DR = 7,
                 UDR = 8, SIR = 9, CIR = 10, SHIR = 11, E1IR = 12, PIR = 13, E2IR = 14, UIR = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic tdo_in = 1'b0;
  logic sys_rst_n, trst_n, tck, tms, tdi, busy, done;
  logic [NL-1:0] cap_tdo;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  jtag_dbg_entry #(.NUM_DEV(N), .IR_LEN(L), .OPCODE(OP), .CLK_DIV(DIV),
                   .PRE_TCKS(D1), .TRST_TCKS(D2), .POST_TCKS(D3)) u0 (
    .clk(clk), .rst(rst), .start(start), .tdo_in(tdo_in),
    .sys_rst_n(sys_rst_n), .trst_n(trst_n), .tck(tck), .tms(tms), .tdi(tdi),
    .busy(busy), .done(done), .cap_tdo(cap_tdo)
  );

  // behavioural chain of TAP devices
  logic [L-1:0] capv = 4'b0001;
  logic [L-1:0] ir  [N];
  logic [L-1:0] act [N];
  int tap = TLR;
  int rises = 0, shifts = 0, post_rti = 0;
  bit upd_seen = 1'b0;

  function automatic int tap_next(input int s, input logic m);
    case (s)
      TLR:  return m ? TLR  : RTI;
      RTI:  return m ? SDR  : RTI;
      SDR:  return m ? SIR  : CDR;
      CDR:  return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR  : PDR;
      PDR:  return m ? E2DR : PDR;
      E2DR: return m ? UDR  : SHDR;
      UDR:  return m ? SDR  : RTI;
      SIR:  return m ? TLR  : CIR;
      CIR:  return m ? E1IR : SHIR;
      SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR  : PIR;
      PIR:  return m ? E2IR : PIR;
      E2IR: return m ? UIR  : SHIR;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tap = TLR;
      upd_seen = 1'b0;
    end else begin
      int nx;
      nx = tap_next(tap, tms);
      rises++;
      if (tap == RTI && upd_seen) post_rti++;
      if (tap == CIR) for (int d = 0; d < N; d++) ir[d] = capv;
      if (tap == SHIR) begin
        shifts++;
        for (int d = N - 1; d > 0; d--) ir[d] = {ir[d-1][0], ir[d][L-1:1]};
        ir[0] = {tdi, ir[0][L-1:1]};
      end
      if (nx == UIR) begin
        for (int d = 0; d < N; d++) act[d] = ir[d];
        upd_seen = 1'b1;
      end
      tap = nx;
    end
  end

  always @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo_in = 1'b0;
    else tdo_in = (tap == SHIR) ? ir[N-1][0] : 1'b0;
  end

  // per-clock observations
  int busy_cyc = 0, rlow = 0, tlow = 0, pre_cyc = 0, done_cnt = 0, hi_len = 0;
  bit seen_trst = 1'b0;
  logic p_tck = 1'b0, p_tms = 1'b0, p_tdi = 1'b0, p_done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic monitor();
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (busy) busy_cyc++;
        if (!sys_rst_n) rlow++;
        if (!trst_n) begin tlow++; seen_trst = 1'b1; end
        if (sys_rst_n) seen_trst = 1'b0;
        if (!sys_rst_n && trst_n && !seen_trst) pre_cyc++;
        if (done) begin
          done_cnt++;
          chk(sys_rst_n && !busy, "R8 release with done", {sys_rst_n, busy}, 2'b10);
        end
        if (done && p_done) chk(1'b0, "R8 done width", 2, 1);
        if (!trst_n) chk(!sys_rst_n, "R3 trst inside reset", sys_rst_n, 0);
        if (busy) chk(!sys_rst_n, "R2 reset held while busy", sys_rst_n, 0);
        if (tck && !p_tck) begin
          chk(trst_n && !sys_rst_n, "R4 tck window", {trst_n, sys_rst_n}, 2'b10);
          chk(tms == p_tms && tdi == p_tdi, "R4 tms/tdi stable at rise", {tms, tdi}, {p_tms, p_tdi});
        end
        if (tck) hi_len++;
        if (!tck && p_tck) begin
          chk(hi_len == DIV, "R4 tck high phase", hi_len, DIV);
          hi_len = 0;
        end
      end
      p_tck = tck; p_tms = tms; p_tdi = tdi; p_done = done;
    end
  endtask

  task automatic run_seq(input logic [L-1:0] cv, input bit inject, input string nm);
    int b0, r0, t0, pc0, d0, rs0, s0, pr0;
    logic [NL-1:0] expc;
    capv = cv;
    expc = {N{cv}};
    b0 = busy_cyc; r0 = rlow; t0 = tlow; pc0 = pre_cyc; d0 = done_cnt;
    rs0 = rises; s0 = shifts; pr0 = post_rti;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !sys_rst_n, {"R2 start response ", nm}, {busy, sys_rst_n}, 2'b10);
    if (inject) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy_cyc - b0 == KT * 2 * DIV, {"R2 busy length ", nm}, busy_cyc - b0, KT * 2 * DIV);
    chk(rlow - r0 == KT * 2 * DIV, {"R2 reset length ", nm}, rlow - r0, KT * 2 * DIV);
    chk(pre_cyc - pc0 == D1 * 2 * DIV, {"R3 reset-to-trst ", nm}, pre_cyc - pc0, D1 * 2 * DIV);
    chk(tlow - t0 == D2 * 2 * DIV, {"R3 trst width ", nm}, tlow - t0, D2 * 2 * DIV);
    chk(rises - rs0 == STEPS + D3, {"R5 rising tck count ", nm}, rises - rs0, STEPS + D3);
    chk(tap == RTI, {"R5 final tap state ", nm}, tap, RTI);
    for (int d = 0; d < N; d++)
      chk(act[d] == OP, {"R5 device instruction ", nm}, act[d], OP);
    chk(post_rti - pr0 == D3, {"R6 idle after update ", nm}, post_rti - pr0, D3);
    chk(shifts - s0 == NL, {"R7 shift count ", nm}, shifts - s0, NL);
    chk(cap_tdo == expc, {"R7 captured tdo ", nm}, cap_tdo, expc);
    chk(sys_rst_n && !busy, {"R8 released ", nm}, {sys_rst_n, busy}, 2'b10);
    if (inject) chk(done_cnt - d0 == 1, {"R9 single done with extra start ", nm}, done_cnt - d0, 1);
    else        chk(done_cnt - d0 == 1, {"R8 single done ", nm}, done_cnt - d0, 1);
  endtask

  initial begin
    fork
      monitor();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sys_rst_n && trst_n && !tck && !busy && !done, "R1 reset state",
        {sys_rst_n, trst_n, tck, busy, done}, 5'b11000);
    run_seq(4'b0001, 1'b0, "capv=0001");
    run_seq(4'b1101, 1'b1, "capv=1101 with R9 extra start");
    repeat (10) @(negedge clk);
    chk(sys_rst_n && trst_n && !tck && !busy && !done, "R1 idle after runs",
        {sys_rst_n, trst_n, tck, busy, done}, 5'b11000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule